// File: doc/BRIEF.md
# Privileged Trap Router

This block holds the privilege level and the trap-handling control registers of a small 32-bit core with machine (M), supervisor (S) and user (U) modes. When the pipeline raises a trap, the block decides whether M-mode or S-mode handles it, saves the return address, cause and trap value in the chosen level's registers, updates the status word, changes the privilege level, and presents the handler address as the next PC in the same cycle.

The block also executes the two trap-return instructions. The M-level return (mret) and the S-level return (sret) each restore the privilege level and the interrupt enable that were saved on entry, and each present the saved return address as the next PC. Software reaches the registers through a simple CSR port that uses the standard CSR addresses. The supervisor status register is not stored on its own. It is a masked window onto the single machine status register.

Top module: `trap_router`

## Requirements
- R1: After reset the privilege is M (`priv` = 2'b11), every control register reads zero and `redirect` is low.
- R2: A trap goes to S-mode only when the current privilege is not M and the delegation bit selected by the low 5 bits of `trap_code` is set. That bit comes from medeleg (0x302) for an exception and from mideleg (0x303) for an interrupt. Every other trap goes to M-mode.
- R3: A trap taken in S-mode writes `trap_pc` to sepc (0x141), the cause to scause (0x142) and `trap_val` to stval (0x143). It copies the old privilege bit 0 into SPP (status bit 8), copies SIE (bit 1) into SPIE (bit 5), clears SIE, sets the privilege to S (2'b01) and redirects to stvec (0x105) with its low two bits cleared.
- R4: A trap taken in M-mode writes mepc (0x341), mcause (0x342) and mtval (0x343). It copies the old privilege into MPP (bits 12:11), copies MIE (bit 3) into MPIE (bit 7), clears MIE, sets the privilege to M and redirects to mtvec (0x305) with its low two bits cleared.
- R5: The stored cause is {`trap_irq`, `trap_code`}, so bit 31 is set for an interrupt and clear for an exception.
- R6: mret sets the privilege to MPP, copies MPIE into MIE, sets MPIE to 1, sets MPP to U and redirects to mepc.
- R7: sret sets the privilege to {0, SPP}, copies SPIE into SIE, sets SPIE to 1, clears SPP and redirects to sepc.
- R8: A read of mstatus (0x300) shows only bits 1, 3, 5, 7, 8 and 12:11 (mask 0x19AA). A read of sstatus (0x100) returns mstatus AND 0x122.
- R9: A write to sstatus changes only bits 1, 5 and 8 of mstatus. All other bits keep their values.
- R10: A trap has priority over mret, mret has priority over sret, and any of the three blocks a CSR write in the same cycle. A blocked CSR write has no effect.
- R11: `redirect` is high exactly in cycles with a trap, mret or sret. In all other cycles `redirect_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_irq | input | 1 | The trap is an interrupt |
| trap_code | input | XLEN-1 | Cause code of the trap |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_val | input | XLEN | Trap value (faulting address or instruction) |
| mret_i | input | 1 | Execute an M-level return |
| sret_i | input | 1 | Execute an S-level return |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| priv | output | 2 | Current privilege level (0 = U, 1 = S, 3 = M) |
| redirect | output | 1 | Next PC is taken from redirect_pc |
| redirect_pc | output | XLEN | Handler or return address |

## Verification
The main sequence configures the core, delegates the S-mode environment call (cause 9) and enters S-mode through mret. The first ecall must land in S-mode, and the following sret must leave the core in S-mode. This pair separates a working delegation path from one that ignores medeleg, and an SPP restore from a return that always drops to U. The bench then clears the delegation bit and repeats the ecall. This time the trap must reach M-mode, which separates a live lookup from a latched one. It also traps from M-mode while the delegation bit is set, to show that the current privilege overrides the bit. An interrupt from U-mode with cause code 37 checks the mideleg path, bit 31 of the cause, and that only the low five bits select the delegation bit. Writes of all ones to mstatus and sstatus, together with cycles that carry a trap, a return and a CSR write at once, separate correct masking and priority from a block that lets every write through.

// File: rtl/trap_router.sv
module trap_router #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_irq,
  input  logic [XLEN-2:0] trap_code,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_val,
  input  logic            mret_i,
  input  logic            sret_i,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [1:0]      priv,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  localparam logic [1:0] PRV_U = 2'd0, PRV_S = 2'd1, PRV_M = 2'd3;
  localparam logic [XLEN-1:0] S_MASK = XLEN'(32'h0000_0122);
  localparam logic [XLEN-1:0] M_MASK = XLEN'(32'h0000_19AA);

  logic [XLEN-1:0] mstatus, medeleg, mideleg, mtvec, stvec;
  logic [XLEN-1:0] mepc, sepc, mcause, scause, mtval, stval;

  wire [4:0] idx    = trap_code[4:0];
  wire       deleg  = (priv != PRV_M) && (trap_irq ? mideleg[idx] : medeleg[idx]);
  wire       do_mr  = mret_i && !trap_valid;
  wire       do_sr  = sret_i && !trap_valid && !mret_i;
  wire       do_csr = csr_we && !trap_valid && !mret_i && !sret_i;
  wire [XLEN-1:0] cause_v = {trap_irq, trap_code};
  wire [XLEN-1:0] tvec    = deleg ? stvec : mtvec;

  assign redirect    = trap_valid || mret_i || sret_i;
  assign redirect_pc = trap_valid ? {tvec[XLEN-1:2], 2'b00} :
                       do_mr      ? mepc :
                       do_sr      ? sepc : '0;

  always_comb begin
    case (csr_addr)
      12'h100: csr_rdata = mstatus & S_MASK;
      12'h105: csr_rdata = stvec;
      12'h141: csr_rdata = sepc;
      12'h142: csr_rdata = scause;
      12'h143: csr_rdata = stval;
      12'h300: csr_rdata = mstatus;
      12'h302: csr_rdata = medeleg;
      12'h303: csr_rdata = mideleg;
      12'h305: csr_rdata = mtvec;
      12'h341: csr_rdata = mepc;
      12'h342: csr_rdata = mcause;
      12'h343: csr_rdata = mtval;
      default: csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv    <= PRV_M;
      mstatus <= '0; medeleg <= '0; mideleg <= '0; mtvec <= '0; stvec <= '0;
      mepc    <= '0; sepc    <= '0; mcause  <= '0; scause <= '0;
      mtval   <= '0; stval   <= '0;
    end else if (trap_valid) begin
      if (deleg) begin
        sepc       <= trap_pc;
        scause     <= cause_v;
        stval      <= trap_val;
        mstatus[8] <= priv[0];
        mstatus[5] <= mstatus[1];
        mstatus[1] <= 1'b0;
        priv       <= PRV_S;
      end else begin
        mepc           <= trap_pc;
        mcause         <= cause_v;
        mtval          <= trap_val;
        mstatus[12:11] <= priv;
        mstatus[7]     <= mstatus[3];
        mstatus[3]     <= 1'b0;
        priv           <= PRV_M;
      end
    end else if (do_mr) begin
      priv           <= mstatus[12:11];
      mstatus[3]     <= mstatus[7];
      mstatus[7]     <= 1'b1;
      mstatus[12:11] <= PRV_U;
    end else if (do_sr) begin
      priv       <= {1'b0, mstatus[8]};
      mstatus[1] <= mstatus[5];
      mstatus[5] <= 1'b1;
      mstatus[8] <= 1'b0;
    end else if (do_csr) begin
      case (csr_addr)
        12'h100: mstatus <= (mstatus & ~S_MASK) | (csr_wdata & S_MASK);
        12'h105: stvec   <= csr_wdata;
        12'h141: sepc    <= csr_wdata;
        12'h142: scause  <= csr_wdata;
        12'h143: stval   <= csr_wdata;
        12'h300: mstatus <= csr_wdata & M_MASK;
        12'h302: medeleg <= csr_wdata;
        12'h303: mideleg <= csr_wdata;
        12'h305: mtvec   <= csr_wdata;
        12'h341: mepc    <= csr_wdata;
        12'h342: mcause  <= csr_wdata;
        12'h343: mtval   <= csr_wdata;
        default: ;
      endcase
    end
  end

  assert_trap_from_m_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv == PRV_M) |=> (priv == PRV_M));
  assert_deleg_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && deleg) |=> (priv == PRV_S && !mstatus[1] && sepc == $past(trap_pc)));
  assert_m_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !deleg) |=> (!mstatus[3] && mstatus[12:11] == $past(priv)));
  assert_mret_clears_mpp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_mr |=> (mstatus[12:11] == PRV_U && mstatus[7]));
  assert_sret_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_sr |=> (priv != PRV_M && !mstatus[8] && mstatus[5]));
  assert_sstatus_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h100) |-> ((csr_rdata & ~S_MASK) == '0));
  assert_sstatus_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_csr && csr_addr == 12'h100) |=> ((mstatus & ~S_MASK) == $past(mstatus & ~S_MASK)));
  assert_priv_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    priv != 2'b10);
endmodule

// File: tb/sim_trap_router.sv
module sim_trap_router;
  logic clk = 0, rst_n = 0;
  logic tv = 0, irq = 0, mr = 0, sr = 0, we = 0;
  logic [30:0] code = '0;
  logic [31:0] tpc = '0, tval = '0, wd = '0;
  logic [11:0] addr = '0;
  logic [31:0] rdata, rpc;
  logic [1:0] priv;
  logic redir;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  trap_router u0 (.clk(clk), .rst_n(rst_n), .trap_valid(tv), .trap_irq(irq),
    .trap_code(code), .trap_pc(tpc), .trap_val(tval), .mret_i(mr), .sret_i(sr),
    .csr_we(we), .csr_addr(addr), .csr_wdata(wd), .csr_rdata(rdata),
    .priv(priv), .redirect(redir), .redirect_pc(rpc));

  logic [1:0]  m_priv;
  logic [31:0] m_st, m_ed, m_id, m_mtv, m_stv, m_mepc, m_sepc, m_mc, m_sc, m_mtl, m_stl;

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      12'h100: return m_st & 32'h122;
      12'h105: return m_stv;  12'h141: return m_sepc;
      12'h142: return m_sc;   12'h143: return m_stl;
      12'h300: return m_st;   12'h302: return m_ed;
      12'h303: return m_id;   12'h305: return m_mtv;
      12'h341: return m_mepc; 12'h342: return m_mc;
      12'h343: return m_mtl;  default: return 0;
    endcase
  endfunction

  function automatic bit m_deleg();
    int i = int'(code) % 32;
    if (m_priv == 2'd3) return 0;
    return irq ? m_id[i] : m_ed[i];
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic [31:0] e_pc;
    bit d;
    #1;
    d = m_deleg();
    e_pc = tv ? ((d ? m_stv : m_mtv) & ~32'h3) : mr ? m_mepc : sr ? m_sepc : 0;
    cmp(req, "priv", {30'b0, priv}, {30'b0, m_priv});
    cmp("R11", "redirect", {31'b0, redir}, {31'b0, (tv | mr | sr)});
    cmp(req, "redirect_pc", rpc, e_pc);
    cmp(req, "csr_rdata", rdata, mread(addr));
    @(posedge clk);
    if (tv) begin
      if (d) begin
        m_sepc = tpc; m_sc = {irq, code}; m_stl = tval;
        m_st[8] = m_priv[0]; m_st[5] = m_st[1]; m_st[1] = 0; m_priv = 2'd1;
      end else begin
        m_mepc = tpc; m_mc = {irq, code}; m_mtl = tval;
        m_st[12:11] = m_priv; m_st[7] = m_st[3]; m_st[3] = 0; m_priv = 2'd3;
      end
    end else if (mr) begin
      m_priv = m_st[12:11]; m_st[3] = m_st[7]; m_st[7] = 1; m_st[12:11] = 0;
    end else if (sr) begin
      m_priv = {1'b0, m_st[8]}; m_st[1] = m_st[5]; m_st[5] = 1; m_st[8] = 0;
    end else if (we) begin
      case (addr)
        12'h100: m_st = (m_st & ~32'h122) | (wd & 32'h122);
        12'h105: m_stv = wd;  12'h141: m_sepc = wd;
        12'h142: m_sc = wd;   12'h143: m_stl = wd;
        12'h300: m_st = wd & 32'h19AA;
        12'h302: m_ed = wd;   12'h303: m_id = wd;
        12'h305: m_mtv = wd;  12'h341: m_mepc = wd;
        12'h342: m_mc = wd;   12'h343: m_mtl = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    tv = 0; irq = 0; mr = 0; sr = 0; we = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    addr = a; wd = d; we = 1; step(req);
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    addr = a; step(req);
  endtask

  task automatic trap(input bit i, input logic [30:0] c, input logic [31:0] pc, input logic [31:0] v,
                      input logic [11:0] a, input string req);
    tv = 1; irq = i; code = c; tpc = pc; tval = v; addr = a; step(req);
  endtask

  task automatic dump(input string req);
    foreach (lst[k]) rd(lst[k], req);
  endtask

  logic [11:0] lst [12] = '{12'h100, 12'h105, 12'h141, 12'h142, 12'h143, 12'h300,
                            12'h302, 12'h303, 12'h305, 12'h341, 12'h342, 12'h343};

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_priv = 2'd3;
    {m_st, m_ed, m_id, m_mtv, m_stv, m_mepc, m_sepc, m_mc, m_sc, m_mtl, m_stl} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    dump("R1");
    wr(12'h300, 32'hFFFF_FFFF, "R8"); rd(12'h300, "R8"); rd(12'h100, "R8");
    wr(12'h300, 32'h0, "R8");
    wr(12'h305, 32'h0000_0101, "R4");
    wr(12'h105, 32'h0000_0203, "R3");
    wr(12'h302, 32'h0000_0200, "R2");
    wr(12'h300, 32'h0000_080A, "R6");
    wr(12'h341, 32'h0000_1000, "R6");
    mr = 1; addr = 12'h300; step("R6");
    rd(12'h300, "R6");
    trap(0, 31'd9, 32'h0000_1004, 32'h0, 12'h142, "R3");
    rd(12'h141, "R3"); rd(12'h100, "R3"); rd(12'h300, "R3");
    sr = 1; addr = 12'h100; step("R7");
    rd(12'h100, "R7");
    wr(12'h302, 32'h0, "R2");
    trap(0, 31'd9, 32'h0000_2008, 32'h55, 12'h342, "R4");
    rd(12'h341, "R4"); rd(12'h343, "R4"); rd(12'h300, "R4");
    wr(12'h300, 32'h0000_1800, "R6");
    wr(12'h341, 32'h0000_3000, "R6");
    mr = 1; addr = 12'h300; step("R6");
    wr(12'h302, 32'h0000_0200, "R2");
    trap(0, 31'd9, 32'h0000_3010, 32'h0, 12'h342, "R2");
    wr(12'h303, 32'h0000_0020, "R2");
    wr(12'h300, 32'h0000_0002, "R6");
    wr(12'h341, 32'h0000_4000, "R6");
    mr = 1; step("R6");
    trap(1, 31'd37, 32'h0000_4004, 32'h0, 12'h142, "R5");
    rd(12'h100, "R5"); dump("R5");
    trap(0, 31'd2, 32'h0000_5000, 32'hDEAD, 12'h342, "R4");
    wr(12'h100, 32'hFFFF_FFFF, "R9"); rd(12'h300, "R9");
    wr(12'h100, 32'h0, "R9"); rd(12'h300, "R9");
    tv = 1; mr = 1; sr = 1; we = 1; code = 31'd3; tpc = 32'h6000; addr = 12'h302; wd = 32'hFFFF_FFFF;
    step("R10");
    rd(12'h302, "R10");
    mr = 1; sr = 1; we = 1; addr = 12'h303; wd = 32'hFFFF_FFFF; step("R10");
    rd(12'h303, "R10");
    sr = 1; we = 1; addr = 12'h305; wd = 32'h0; step("R10");
    rd(12'h305, "R10"); rd(12'h000, "R11");
    dump("R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule